// File: doc/BRIEF.md
# Packet-Granular Stream Merger

This block merges eight incoming word streams into one outgoing stream. Four sources carry traffic received from Ethernet ports and four carry traffic from the host processor path. Each word is 64 bits of data with an 8-bit control tag. A packet starts with one or more prepended header words, each with a nonzero tag. The header tagged 0xff carries the length and the source port. Body words follow with a tag of zero. The first nonzero tag after the body closes the packet.

The merger grants one source at a time and forwards a complete packet from it before it selects again. Selection is round-robin. The search begins at the source after the one granted last, and sources with nothing pending are skipped. Words pass through untouched. Back-pressure works in both directions. The outgoing `out_valid` is raised only while `out_ready` is high, so a word moves in exactly the cycles where `out_valid` is high. Only the granted source sees its `in_ready` asserted, and only while the downstream side is ready. A source must hold its word stable while its `in_valid` is high and it has not yet seen `in_ready`.

Top module: `pktarb_top`

## Requirements
- R1: After reset no source is granted, every `in_ready` bit is 0, `out_valid` is 0, and the round-robin search starts at source 0.
- R2: When idle, the merger grants the first source with a pending word, searching upward from the source after the last granted one and wrapping from 7 to 0.
- R3: Once a source is granted, only its words appear on the output until its packet has closed. Words from other sources are never interleaved.
- R4: Nonzero-tag words before the first zero-tag word of a packet are header words and do not close it. The first nonzero tag of any value after a zero-tag word closes the packet.
- R5: `out_valid` is high only while `out_ready` is high. A word is transferred exactly when `out_valid` is high.
- R6: At most one `in_ready` bit is high, and only the bit of the granted source.
- R7: Data and tag of every word leave unchanged and in the order the source offered them.
- R8: While `out_ready` is low, no word is accepted or emitted and the grant is held. When it returns, the packet resumes with no word lost or repeated.
- R9: After the closing word is transferred, one cycle passes with no transfer before the next source's first word can move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 8 | Per-source word pending |
| in_ready | output | 8 | Per-source accept, granted source only |
| in_data | input | 8x64 | Per-source data word |
| in_ctrl | input | 8x8 | Per-source control tag |
| out_valid | output | 1 | Word transferred this cycle |
| out_ready | input | 1 | Downstream can accept a word |
| out_data | output | 64 | Forwarded data word |
| out_ctrl | output | 8 | Forwarded control tag |

## Verification
A downstream stall can land in the same cycle as a source's body or closing word. The stall must win: no transfer, a held grant and no early release. The bench drops `out_ready` for several cycles in the middle of a packet and checks at each falling clock edge that no `in_ready` or `out_valid` is raised. It then compares the recovered output word by word with the packet that was sent. The hand-over from the closing word to a new grant can also meet a second source that is already waiting. The bench judges this from the cycle stamps of the two packets' boundary words.

// File: rtl/pktarb_pkg.sv
package pktarb_pkg;
  localparam int unsigned DEF_NPORT  = 8;
  localparam int unsigned DEF_DATA_W = 64;
  localparam int unsigned DEF_CTRL_W = 8;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HOLD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/pktarb_rr_pick.sv
module pktarb_rr_pick #(
  parameter int unsigned NPORT = 8,
  parameter int unsigned IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic [NPORT-1:0] req,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NPORT; k++) begin
      logic [IDX_W:0] cand;
      cand = {1'b0, start} + (IDX_W+1)'(k);
      if (cand >= (IDX_W+1)'(NPORT)) cand = cand - (IDX_W+1)'(NPORT);
      if (!found && req[cand[IDX_W-1:0]]) begin
        found = 1'b1;
        pick  = cand[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pktarb_edge.sv
module pktarb_edge #(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              last_beat
);
  logic in_body_q;

  assign last_beat = beat && (ctrl != '0) && in_body_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_body_q <= 1'b0;
    end else if (last_beat) begin
      in_body_q <= 1'b0;
    end else if (beat && ctrl == '0) begin
      in_body_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pktarb_sel.sv
module pktarb_sel #(
  parameter int unsigned NPORT  = 8,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned IDX_W  = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                          hold,
  input  logic [IDX_W-1:0]              grant,
  input  logic [NPORT-1:0]              in_valid,
  output logic [NPORT-1:0]              in_ready,
  input  logic [NPORT-1:0][DATA_W-1:0]  in_data,
  input  logic [NPORT-1:0][CTRL_W-1:0]  in_ctrl,
  input  logic                          out_ready,
  output logic                          out_valid,
  output logic [DATA_W-1:0]             out_data,
  output logic [CTRL_W-1:0]             out_ctrl
);
  for (genvar i = 0; i < NPORT; i++) begin : g_rdy
    assign in_ready[i] = hold && out_ready && (grant == IDX_W'(i));
  end

  assign out_valid = hold && out_ready && in_valid[grant];
  assign out_data  = in_data[grant];
  assign out_ctrl  = in_ctrl[grant];
endmodule

// File: rtl/pktarb_top.sv
module pktarb_top
  import pktarb_pkg::*;
#(
  parameter int unsigned NPORT  = DEF_NPORT,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CTRL_W = DEF_CTRL_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              in_valid,
  output logic [NPORT-1:0]              in_ready,
  input  logic [NPORT-1:0][DATA_W-1:0]  in_data,
  input  logic [NPORT-1:0][CTRL_W-1:0]  in_ctrl,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [DATA_W-1:0]             out_data,
  output logic [CTRL_W-1:0]             out_ctrl
);
  localparam int unsigned IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1;

  arb_state_e      state_q;
  logic [IDX_W-1:0] grant_q;
  logic [IDX_W-1:0] ptr_q;
  logic             found;
  logic [IDX_W-1:0] pick;
  logic             last_beat;
  logic             hold;

  assign hold = (state_q == ARB_HOLD);

  pktarb_rr_pick #(.NPORT(NPORT), .IDX_W(IDX_W)) u_pick (
    .req   (in_valid),
    .start (ptr_q),
    .found (found),
    .pick  (pick)
  );

  pktarb_sel #(.NPORT(NPORT), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .IDX_W(IDX_W)) u_sel (
    .hold      (hold),
    .grant     (grant_q),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_ctrl   (in_ctrl),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ctrl  (out_ctrl)
  );

  pktarb_edge #(.CTRL_W(CTRL_W)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (out_valid),
    .ctrl      (out_ctrl),
    .last_beat (last_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
      ptr_q   <= '0;
    end else if (!hold) begin
      if (found) begin
        state_q <= ARB_HOLD;
        grant_q <= pick;
      end
    end else if (last_beat) begin
      state_q <= ARB_IDLE;
      ptr_q   <= (grant_q == IDX_W'(NPORT-1)) ? '0 : grant_q + 1'b1;
    end
  end
endmodule

// File: rtl/pktarb_chk.sv
module pktarb_chk #(
  parameter int unsigned NPORT  = 8,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORT-1:0]  in_valid,
  input logic [NPORT-1:0]  in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CTRL_W-1:0] out_ctrl,
  input logic              hold,
  input logic [IDX_W-1:0]  grant,
  input logic [IDX_W-1:0]  ptr,
  input logic              last_beat
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (in_ready == '0 && !out_valid)); // R1

  AST_PTR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> ptr == (($past(grant) == IDX_W'(NPORT-1)) ? '0 : $past(grant) + 1'b1)); // R2

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !last_beat) |=> (hold && $stable(grant))); // R3

  AST_CLOSE_ON_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> ($past(out_valid) && $past(out_ctrl) != '0)); // R4

  AST_NO_WRITE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ready); // R5

  AST_MOVE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == |(in_valid & in_ready)); // R5

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready)); // R6

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !out_ready) |=> (hold && $stable(grant))); // R8
endmodule

bind pktarb_top pktarb_chk #(.NPORT(NPORT), .CTRL_W(CTRL_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_ctrl  (out_ctrl),
  .hold      (hold),
  .grant     (grant_q),
  .ptr       (ptr_q),
  .last_beat (last_beat)
);

// File: tb/test_pktarb_top.sv
module test_pktarb_top;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] in_valid;
  logic [NP-1:0] in_ready;
  logic [NP-1:0][63:0] in_data;
  logic [NP-1:0][7:0]  in_ctrl;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;

  always #10 clk = ~clk;

  pktarb_top i_pktarb_top (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_ctrl(in_ctrl),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ctrl(out_ctrl)
  );

  // source models
  logic [63:0] src_data [NP][64];
  logic [7:0]  src_ctrl [NP][64];
  int src_len [NP];
  int src_rd  [NP];

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      in_valid[i] = src_rd[i] < src_len[i];
      in_data[i]  = src_data[i][src_rd[i][5:0]];
      in_ctrl[i]  = src_ctrl[i][src_rd[i][5:0]];
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < NP; i++)
      if (in_valid[i] && in_ready[i]) src_rd[i] <= src_rd[i] + 1;
  end

  // sink log
  logic [63:0] log_data [512];
  logic [7:0]  log_ctrl [512];
  int          log_cyc  [512];
  int log_cnt = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (out_valid && out_ready) begin
      log_data[log_cnt] <= out_data;
      log_ctrl[log_cnt] <= out_ctrl;
      log_cyc[log_cnt]  <= cyc;
      log_cnt <= log_cnt + 1;
    end
  end

  // expected stream
  logic [63:0] exp_data [512];
  logic [7:0]  exp_ctrl [512];
  int exp_cnt = 0;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] gen_data(int p, int seq, int k);
    return {8'(p), 8'(seq), 16'(k), 32'hC0DE_0000 | 32'(k)};
  endfunction

  function automatic logic [7:0] gen_ctrl(int k, int nh, int nb, logic [7:0] eopc);
    if (k == 0) return 8'hff;
    if (k < nh) return 8'h20 + 8'(k);
    if (k < nh + nb) return 8'h00;
    return eopc;
  endfunction

  task automatic load_pkt(int p, int seq, int nh, int nb, logic [7:0] eopc);
    for (int k = 0; k < nh + nb + 1; k++) begin
      src_data[p][src_len[p] + k] = gen_data(p, seq, k);
      src_ctrl[p][src_len[p] + k] = gen_ctrl(k, nh, nb, eopc);
    end
    src_len[p] = src_len[p] + nh + nb + 1;
  endtask

  task automatic exp_pkt(int p, int seq, int nh, int nb, logic [7:0] eopc);
    for (int k = 0; k < nh + nb + 1; k++) begin
      exp_data[exp_cnt] = gen_data(p, seq, k);
      exp_ctrl[exp_cnt] = gen_ctrl(k, nh, nb, eopc);
      exp_cnt++;
    end
  endtask

  task automatic drain_and_compare(input string req, input int from);
    int guard = 0;
    while (log_cnt < exp_cnt && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    chk(log_cnt == exp_cnt, req, 72'(log_cnt), 72'(exp_cnt));
    for (int i = from; i < exp_cnt; i++)
      chk({log_ctrl[i], log_data[i]} === {exp_ctrl[i], exp_data[i]}, req,
          {log_ctrl[i], log_data[i]}, {exp_ctrl[i], exp_data[i]});
  endtask

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == '0, "R1 in_ready idle", 72'(in_ready), 72'(0));
    chk(out_valid == 1'b0, "R1 out_valid idle", 72'(out_valid), 72'(0));
  endtask

  // R7 R4 R1: single packet from port 3, pointer starts at 0
  task automatic t_single();
    int b = exp_cnt;
    load_pkt(3, 1, 2, 2, 8'h10);
    exp_pkt(3, 1, 2, 2, 8'h10);
    drain_and_compare("R7 single packet", b);
  endtask

  // R2 R3: all eight pending, last grant 3 -> order 4..7,0..3
  task automatic t_all();
    int b = exp_cnt;
    for (int p = 0; p < NP; p++) load_pkt(p, 2, 1, p % 3 + 1, 8'h10);
    for (int j = 0; j < NP; j++) exp_pkt((4 + j) % NP, 2, 1, ((4 + j) % NP) % 3 + 1, 8'h10);
    drain_and_compare("R2 R3 rotation order", b);
  endtask

  // R2: skip empty ports, pointer at 4 -> 6 then 1
  task automatic t_skip();
    int b = exp_cnt;
    load_pkt(1, 3, 1, 1, 8'h10);
    load_pkt(6, 3, 1, 2, 8'h10);
    exp_pkt(6, 3, 1, 2, 8'h10);
    exp_pkt(1, 3, 1, 1, 8'h10);
    drain_and_compare("R2 skip idle ports", b);
  endtask

  // R8 R5: downstream stall in mid packet
  task automatic t_stall();
    int b = exp_cnt;
    load_pkt(2, 4, 1, 4, 8'h10);
    exp_pkt(2, 4, 1, 4, 8'h10);
    @(negedge clk); @(negedge clk); @(negedge clk);
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(in_ready == '0 && out_valid == 1'b0, "R8 stall no transfer",
          72'({in_ready, out_valid}), 72'(0));
    end
    out_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 no write while stalled", 72'(out_valid), 72'(0));
    @(negedge clk);
    out_ready = 1'b1;
    drain_and_compare("R8 resume without loss", b);
  endtask

  // R4: three header words and a closing tag other than 0x10
  task automatic t_headers();
    int b = exp_cnt;
    load_pkt(7, 5, 3, 2, 8'h40);
    load_pkt(7, 6, 1, 1, 8'h10);
    exp_pkt(7, 5, 3, 2, 8'h40);
    exp_pkt(7, 6, 1, 1, 8'h10);
    drain_and_compare("R4 headers and close tag", b);
  endtask

  // R6 R9: two ports waiting, pointer at 0 -> 0 then 5
  task automatic t_handover();
    int b = exp_cnt;
    bit ok = 1'b1;
    logic [7:0] bad = '0;
    load_pkt(0, 7, 1, 3, 8'h10);
    load_pkt(5, 7, 1, 3, 8'h10);
    exp_pkt(0, 7, 1, 3, 8'h10);
    exp_pkt(5, 7, 1, 3, 8'h10);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (out_valid && (in_ready != (8'b1 << out_data[63:56]))) begin ok = 1'b0; bad = in_ready; end
    end
    chk(ok, "R6 ready to granted only", 72'(bad), 72'(0));
    drain_and_compare("R3 two waiting packets", b);
    chk(log_cyc[b + 5] - log_cyc[b + 4] == 2, "R9 idle cycle at handover",
        72'(log_cyc[b + 5] - log_cyc[b + 4]), 72'(2));
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      src_len[i] = 0;
      src_rd[i] = 0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_all();
    t_skip();
    t_stall();
    t_headers();
    t_handover();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule